// File: doc/BRIEF.md
# Host Port Slave with Ready Handshake

This block is the target side of a processor-facing host port. An external host reaches it over a strobe-based bus. The host drives a chip select, two data strobes, a two-bit register selector, a read/write line and a halfword marker. The block decodes each access to one of three registers: a control word, a byte address pointer, or a data window. The data window either keeps the pointer where it is or advances it by one word after the access. A word memory sits behind the data window, and it answers after a programmable number of clock cycles, in the way a DMA channel would.

The `rdy` output is high while the port is busy and low when the host may go on. It is forced low whenever chip select is inactive. It rises when a data read opens, because the memory has to fill the data window first. It also rises after a data write completes and after an auto-incrementing read completes, while the internal transfer finishes. With `HOST_W` = 16, two strobes carry one 32-bit word. The first strobe moves bits 15:0 and the second moves bits 31:16. With `HOST_W` = 32, each strobe moves a whole word. All bus inputs are sampled on `clk`.

Top module: `hport_slave`

## Requirements
- R1: An access happens only while `cs_n` is low and `ds1` differs from `ds2`. Strobes at equal levels leave every register unchanged. Either strobe line may be the one that toggles.
- R2: The selector code picks the target. 00 is the control word, 10 is the address pointer, 01 is the data window with pointer advance, and 11 is the data window without advance. In 16-bit mode `hwid`=0 carries bits 15:0 and `hwid`=1 carries bits 31:16. Written values read back unchanged.
- R3: `rdy` is low whenever `cs_n` is high, even while an internal transfer is still running.
- R4: When the first strobe of a data-window read falls, `rdy` is high for exactly `LATENCY` cycles. After that, `rdata` shows the memory word at the pointer.
- R5: After the last strobe of a data-window write rises, `rdy` is high for exactly `LATENCY` cycles. The assembled word is then stored at the pointer.
- R6: Accesses to the control word or the address pointer never raise `rdy`. A read of the data window's second halfword without advance does not raise it either.
- R7: A code-01 access advances the pointer by 4 after its last strobe. After the last strobe of a code-01 read, `rdy` is high for `LATENCY` cycles.
- R8: If chip select is dropped while a transfer is still running, `rdy` is high again as soon as chip select returns.
- R9: A write whose strobe ends while `rdy` is high is discarded.
- R10: With `HOST_W`=32, a single strobe writes or reads a full 32-bit word, and `hwid` is ignored.
- R11: The selector, read/write and halfword inputs are taken at the strobe's falling edge. Changes to them later in the same strobe have no effect.
- R12: After reset, `rdy` is low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples every bus input |
| rst_n | input | 1 | Active-low reset; asserts at once, releases on the clock |
| cs_n | input | 1 | Chip select, active low |
| ds1 | input | 1 | Data strobe line A |
| ds2 | input | 1 | Data strobe line B |
| cntl | input | 2 | Register selector code |
| rnw | input | 1 | 1 = read, 0 = write |
| hwid | input | 1 | Halfword marker (16-bit mode only) |
| wdata | input | HOST_W | Host write data |
| rdata | output | HOST_W | Read data for the selected register lane |
| rdy | output | 1 | High = host must hold the strobe |

## Verification
The bench builds two copies of the block. One uses `HOST_W`=16 with `LATENCY`=6. This long busy window leaves room to drop chip select, raise it again and end a strobe, all while the memory is still working, which exercises the R3, R8 and R9 cases. The other uses `HOST_W`=32 with `LATENCY`=2, which covers full-word strobes and a short busy window. In both copies, measuring the exact number of busy cycles ties `rdy` directly to the `LATENCY` parameter.

// File: rtl/hport_pkg.sv
package hport_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'b00,
    SEL_DINC = 2'b01,
    SEL_ADDR = 2'b10,
    SEL_DFIX = 2'b11
  } hsel_e;

  typedef struct packed {
    hsel_e reg_sel;
    logic  rnw;
    logic  hw2;
  } hacc_t;

endpackage

// File: rtl/hport_strobe.sv
module hport_strobe
  import hport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       ds1,
  input  logic       ds2,
  input  logic [1:0] cntl,
  input  logic       rnw,
  input  logic       hwid,
  output logic       fall_p,
  output logic       rise_p,
  output hacc_t      acc
);

  logic  act;
  logic  act_q;
  hacc_t acc_in;
  hacc_t acc_q;

  // strobe active only with chip select low and strobes at opposite levels
  assign act    = ~(~(ds1 ^ ds2) | cs_n);
  assign acc_in = '{reg_sel: hsel_e'(cntl), rnw: rnw, hw2: hwid};
  assign fall_p = act & ~act_q;
  assign rise_p = ~act & act_q;
  assign acc    = fall_p ? acc_in : acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      acc_q <= '0;
    end else begin
      act_q <= act;
      if (fall_p) acc_q <= acc_in;
    end
  end

endmodule

// File: rtl/hport_engine.sv
module hport_engine #(
  parameter int MEM_WORDS = 64,
  parameter int LATENCY   = 4,
  parameter int IDX_W     = $clog2(MEM_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_fetch,
  input  logic             start_store,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wword,
  output logic             busy,
  output logic             fill_p,
  output logic [31:0]      rword
);

  localparam int CNT_W = $clog2(LATENCY + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             store_q, store_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [31:0]      word_q, word_d;
  logic [31:0]      mem_q [MEM_WORDS];
  logic             last;

  assign busy   = (cnt_q != '0);
  assign last   = (cnt_q == CNT_W'(1));
  assign fill_p = last & ~store_q;
  assign rword  = mem_q[idx_q];

  always_comb begin
    cnt_d   = cnt_q;
    store_d = store_q;
    idx_d   = idx_q;
    word_d  = word_q;
    if (start_fetch | start_store) begin
      cnt_d   = CNT_W'(LATENCY);
      store_d = start_store;
      idx_d   = idx;
      word_d  = wword;
    end else if (busy) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      store_q <= 1'b0;
      idx_q   <= '0;
      word_q  <= '0;
    end else begin
      cnt_q   <= cnt_d;
      store_q <= store_d;
      idx_q   <= idx_d;
      word_q  <= word_d;
    end
  end

  always_ff @(posedge clk) begin
    if (last & store_q) mem_q[idx_q] <= word_q;
  end

endmodule

// File: rtl/hport_slave.sv
module hport_slave
  import hport_pkg::*;
#(
  parameter int HOST_W    = 16,
  parameter int MEM_WORDS = 64,
  parameter int LATENCY   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ds1,
  input  logic              ds2,
  input  logic [1:0]        cntl,
  input  logic              rnw,
  input  logic              hwid,
  input  logic [HOST_W-1:0] wdata,
  output logic [HOST_W-1:0] rdata,
  output logic              rdy
);

  localparam int          IDX_W = $clog2(MEM_WORDS);
  localparam logic [31:0] STEP  = 32'd4;

  logic [1:0]  rs_q;
  logic        rst_s;
  logic        fall_p, rise_p;
  hacc_t       acc;
  logic [31:0] ctrl_q, ctrl_d, addr_q, addr_d, data_q, data_d;
  logic        pend_q, pend_d;
  logic [31:0] wd32, wmask, rsel, addr_inc;
  logic        lo_en, hi_en, first, second;
  logic        eng_busy, fill_p, busy_any;
  logic [31:0] rword, store_word;
  logic        do_rise, wr_ev, is_data;
  logic        fetch_req, fetch_go, store_go, ainc_rd;
  logic [IDX_W-1:0] eng_idx;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  hport_strobe u_strobe (
    .clk(clk), .rst_n(rst_s), .cs_n(cs_n), .ds1(ds1), .ds2(ds2),
    .cntl(cntl), .rnw(rnw), .hwid(hwid),
    .fall_p(fall_p), .rise_p(rise_p), .acc(acc)
  );

  always_comb begin
    case (acc.reg_sel)
      SEL_CTRL: rsel = ctrl_q;
      SEL_ADDR: rsel = addr_q;
      default:  rsel = data_q;
    endcase
  end

  generate
    if (HOST_W == 16) begin : g_half
      assign wd32   = {wdata, wdata};
      assign lo_en  = ~acc.hw2;
      assign hi_en  = acc.hw2;
      assign first  = ~acc.hw2;
      assign second = acc.hw2;
      assign rdata  = acc.hw2 ? rsel[31:16] : rsel[15:0];
    end else begin : g_full
      assign wd32   = 32'(wdata);
      assign lo_en  = 1'b1;
      assign hi_en  = 1'b1;
      assign first  = 1'b1;
      assign second = 1'b1;
      assign rdata  = HOST_W'(rsel);
    end
  endgenerate

  assign wmask    = {{16{hi_en}}, {16{lo_en}}};
  assign busy_any = eng_busy | pend_q;
  assign rdy      = busy_any & ~cs_n;
  assign is_data  = acc.reg_sel[0];
  assign addr_inc = addr_q + STEP;

  // event decode; a strobe ending while busy is ignored
  assign do_rise    = rise_p & ~busy_any;
  assign wr_ev      = do_rise & ~acc.rnw;
  assign store_go   = wr_ev & is_data & second;
  assign ainc_rd    = do_rise & acc.rnw & second & (acc.reg_sel == SEL_DINC);
  assign fetch_req  = fall_p & acc.rnw & is_data & first;
  assign fetch_go   = (fetch_req | pend_q) & ~eng_busy;
  assign store_word = (data_q & ~wmask) | (wd32 & wmask);
  assign eng_idx    = ainc_rd ? addr_inc[IDX_W+1:2] : addr_q[IDX_W+1:2];

  always_comb begin
    ctrl_d = ctrl_q;
    addr_d = addr_q;
    data_d = data_q;
    pend_d = (pend_q | fetch_req) & ~fetch_go;
    if (wr_ev & (acc.reg_sel == SEL_CTRL)) ctrl_d = (ctrl_q & ~wmask) | (wd32 & wmask);
    if (wr_ev & (acc.reg_sel == SEL_ADDR)) begin
      addr_d = (addr_q & ~wmask) | (wd32 & wmask);
    end else if (ainc_rd | (store_go & (acc.reg_sel == SEL_DINC))) begin
      addr_d = addr_inc;
    end
    if (wr_ev & is_data) data_d = store_word;
    else if (fill_p)     data_d = rword;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ctrl_q <= '0;
      addr_q <= '0;
      data_q <= '0;
      pend_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      addr_q <= addr_d;
      data_q <= data_d;
      pend_q <= pend_d;
    end
  end

  hport_engine #(.MEM_WORDS(MEM_WORDS), .LATENCY(LATENCY), .IDX_W(IDX_W)) u_engine (
    .clk(clk), .rst_n(rst_s),
    .start_fetch(fetch_go | ainc_rd), .start_store(store_go),
    .idx(eng_idx), .wword(store_word),
    .busy(eng_busy), .fill_p(fill_p), .rword(rword)
  );

endmodule

// File: rtl/hport_slave_chk.sv
module hport_slave_chk
  import hport_pkg::*;
#(
  parameter int HOST_W = 16
) (
  input logic        clk,
  input logic        rst_s,
  input logic        fall_p,
  input logic        rise_p,
  input hacc_t       acc,
  input logic        busy_any,
  input logic [31:0] addr_q,
  input logic [31:0] ctrl_q
);

  logic first_c, second_c;
  assign first_c  = (HOST_W == 32) || !acc.hw2;
  assign second_c = (HOST_W == 32) || acc.hw2;

  // R6
  ctrl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (fall_p && !acc.reg_sel[0] && !busy_any) |=> !busy_any);

  // R4
  fetch_busy_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (fall_p && acc.rnw && acc.reg_sel[0] && first_c) |=> busy_any);

  // R5
  store_busy_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (rise_p && !acc.rnw && acc.reg_sel[0] && second_c && !busy_any) |=> busy_any);

  // R7
  inc_addr_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (rise_p && acc.reg_sel == SEL_DINC && second_c && !busy_any)
      |=> (addr_q == $past(addr_q) + 32'd4));

  // R9
  drop_write_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (rise_p && !acc.rnw && busy_any) |=> ($stable(addr_q) && $stable(ctrl_q)));

endmodule

bind hport_slave hport_slave_chk #(.HOST_W(HOST_W)) u_chk (
  .clk(clk), .rst_s(rst_s), .fall_p(fall_p), .rise_p(rise_p), .acc(acc),
  .busy_any(busy_any), .addr_q(addr_q), .ctrl_q(ctrl_q)
);

// File: tb/tb_hport_slave.sv
module tb_hport_slave;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs16, cs32, ds1, ds2, rnw, hwid;
  logic [1:0]  cntl;
  logic [31:0] wdata;
  logic [15:0] rdata16;
  logic [31:0] rdata32;
  logic        rdy16, rdy32;
  bit          use_ds1 = 1'b0;

  int nchk = 0;
  int nerr = 0;

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t        q[$];
  event        obs_ev;
  logic [31:0] obs_val;

  always #2.5 clk = ~clk;

  hport_slave #(.HOST_W(16), .MEM_WORDS(64), .LATENCY(6)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs16), .ds1(ds1), .ds2(ds2), .cntl(cntl),
    .rnw(rnw), .hwid(hwid), .wdata(wdata[15:0]), .rdata(rdata16), .rdy(rdy16)
  );

  hport_slave #(.HOST_W(32), .MEM_WORDS(16), .LATENCY(2)) dut_w (
    .clk(clk), .rst_n(rst_n), .cs_n(cs32), .ds1(ds1), .ds2(ds2), .cntl(cntl),
    .rnw(rnw), .hwid(hwid), .wdata(wdata), .rdata(rdata32), .rdy(rdy32)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic cur_rdy(bit w);
    return w ? rdy32 : rdy16;
  endfunction

  function automatic logic [31:0] cur_rdata(bit w);
    return w ? rdata32 : {16'h0, rdata16};
  endfunction

  task automatic set_cs(bit w, logic v);
    if (w) cs32 = v; else cs16 = v;
  endtask

  task automatic strobe(logic on);
    if (use_ds1) ds1 = on; else ds2 = on;
  endtask

  task automatic acc(bit w, logic [1:0] c, bit rd, bit hw, logic [31:0] wd, bit wiggle,
                     output logic [31:0] rv, output int pre, output int post);
    @(negedge clk);
    cntl = c; rnw = rd; hwid = hw; wdata = wd; set_cs(w, 1'b0);
    @(negedge clk);
    strobe(1'b1);
    @(negedge clk);
    if (wiggle) cntl = ~c;
    pre = 0;
    while (cur_rdy(w)) begin pre++; @(negedge clk); end
    rv = cur_rdata(w);
    strobe(1'b0);
    @(negedge clk);
    post = 0;
    while (cur_rdy(w)) begin post++; @(negedge clk); end
    set_cs(w, 1'b1);
  endtask

  task automatic wr(bit w, logic [1:0] c, bit hw, logic [31:0] wd, output int post);
    logic [31:0] rv;
    int pre;
    acc(w, c, 1'b0, hw, wd, 1'b0, rv, pre, post);
  endtask

  task automatic rd_exp(bit w, logic [1:0] c, bit hw, logic [31:0] e, string tag,
                        output int pre, output int post);
    logic [31:0] rv;
    q.push_back('{v: e, tag: tag});
    acc(w, c, 1'b1, hw, 32'h0, 1'b0, rv, pre, post);
    obs_val = rv;
    ->obs_ev;
  endtask

  task automatic finish_up();
    if (q.size() != 0) begin
      nchk++; nerr++;
      $display("FAIL scoreboard actual %0d expected 0 pending items", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      exp_t e;
      @(obs_ev);
      if (q.size() == 0) begin
        nchk++; nerr++;
        $display("FAIL scoreboard actual %h expected none", obs_val);
      end else begin
        e = q.pop_front();
        chk(e.tag, obs_val, e.v);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_up();
  end

  initial begin
    int pre, post;
    rst_n = 1'b0; cs16 = 1'b1; cs32 = 1'b1; ds1 = 1'b0; ds2 = 1'b0;
    rnw = 1'b1; hwid = 1'b0; cntl = 2'b00; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk("R12 rdy16", {31'h0, rdy16}, 32'h0);
    chk("R12 rdy32", {31'h0, rdy32}, 32'h0);
    chk("R12 rdata16", {16'h0, rdata16}, 32'h0);
    rd_exp(0, 2'b00, 0, 32'h0, "R12 ctrl reads zero", pre, post);
    chk("R6 ctrl read busy", pre, 0);

    // R2 / R6 register access
    wr(0, 2'b10, 0, 32'h0010, post); chk("R6 addr lo busy", post, 0);
    wr(0, 2'b10, 1, 32'h0000, post); chk("R6 addr hi busy", post, 0);
    wr(0, 2'b00, 0, 32'hBEEF, post); chk("R6 ctrl lo busy", post, 0);
    wr(0, 2'b00, 1, 32'h1234, post);
    rd_exp(0, 2'b00, 0, 32'hBEEF, "R2 ctrl lo", pre, post);
    rd_exp(0, 2'b00, 1, 32'h1234, "R2 ctrl hi", pre, post);
    rd_exp(0, 2'b10, 0, 32'h0010, "R2 addr lo", pre, post);

    // R5 data write without advance
    wr(0, 2'b11, 0, 32'h5678, post); chk("R6 data first half write busy", post, 0);
    wr(0, 2'b11, 1, 32'h9ABC, post); chk("R5 store busy cycles", post, 6);
    rd_exp(0, 2'b10, 0, 32'h0010, "R7 fixed write keeps pointer", pre, post);

    // R4 data read
    rd_exp(0, 2'b11, 0, 32'h5678, "R4 fetched lo", pre, post);
    chk("R4 fetch busy cycles", pre, 6);
    rd_exp(0, 2'b11, 1, 32'h9ABC, "R4 fetched hi", pre, post);
    chk("R6 fixed second read no busy", pre + post, 0);

    // R7 auto-increment
    wr(0, 2'b10, 0, 32'h0030, post);
    wr(0, 2'b01, 0, 32'h1111, post);
    wr(0, 2'b01, 1, 32'h2222, post); chk("R7 inc write busy", post, 6);
    rd_exp(0, 2'b10, 0, 32'h0034, "R7 pointer after inc write", pre, post);
    wr(0, 2'b10, 0, 32'h0010, post);
    rd_exp(0, 2'b01, 0, 32'h5678, "R7 inc read lo", pre, post);
    chk("R4 inc read fetch busy", pre, 6);
    rd_exp(0, 2'b01, 1, 32'h9ABC, "R7 inc read hi", pre, post);
    chk("R7 inc read tail busy", post, 6);
    rd_exp(0, 2'b10, 0, 32'h0014, "R7 pointer after inc read", pre, post);
    wr(0, 2'b10, 0, 32'h0030, post);
    rd_exp(0, 2'b01, 0, 32'h1111, "R7 stored via inc lo", pre, post);
    rd_exp(0, 2'b01, 1, 32'h2222, "R7 stored via inc hi", pre, post);

    // R1 strobes at equal levels do nothing
    @(negedge clk);
    cntl = 2'b10; rnw = 1'b0; hwid = 1'b0; wdata = 32'h0099; cs16 = 1'b0;
    @(negedge clk); ds1 = 1'b1; ds2 = 1'b1;
    repeat (2) @(negedge clk); ds1 = 1'b0; ds2 = 1'b0;
    @(negedge clk); cs16 = 1'b1;
    rd_exp(0, 2'b10, 0, 32'h0034, "R1 equal strobes ignored", pre, post);
    use_ds1 = 1'b1;
    wr(0, 2'b10, 0, 32'h0020, post);
    use_ds1 = 1'b0;
    rd_exp(0, 2'b10, 0, 32'h0020, "R1 strobe on line A", pre, post);

    // R11 selector changes after the fall are ignored
    begin
      logic [31:0] rv;
      acc(0, 2'b10, 1'b0, 1'b0, 32'h0024, 1'b1, rv, pre, post);
    end
    chk("R11 late selector no busy", post, 0);
    rd_exp(0, 2'b10, 0, 32'h0024, "R11 pointer written", pre, post);
    rd_exp(0, 2'b00, 0, 32'hBEEF, "R11 ctrl untouched", pre, post);

    // R3 / R8 / R9 chip select dropped mid-transfer, early write end
    wr(0, 2'b11, 0, 32'h00AB, post);
    @(negedge clk); cntl = 2'b11; rnw = 1'b0; hwid = 1'b1; wdata = 32'h00CD; cs16 = 1'b0;
    @(negedge clk); ds2 = 1'b1;
    @(negedge clk); ds2 = 1'b0;
    @(negedge clk); cs16 = 1'b1; #1;
    chk("R3 rdy low with cs high", {31'h0, rdy16}, 32'h0);
    @(negedge clk); cntl = 2'b10; rnw = 1'b0; hwid = 1'b0; wdata = 32'h0040; cs16 = 1'b0; #1;
    chk("R8 rdy high at cs return", {31'h0, rdy16}, 32'h1);
    @(negedge clk); ds2 = 1'b1;
    @(negedge clk); ds2 = 1'b0;
    @(negedge clk); cs16 = 1'b1;
    repeat (8) @(negedge clk);
    rd_exp(0, 2'b10, 0, 32'h0024, "R9 early write discarded", pre, post);
    rd_exp(0, 2'b11, 1, 32'h00CD, "R5 stored word hi", pre, post);
    chk("R4 refetch busy", pre, 0);
    rd_exp(0, 2'b11, 0, 32'h00AB, "R5 stored word lo", pre, post);
    chk("R4 fetch after store busy", pre, 6);

    // R10 full-word mode
    wr(1, 2'b10, 0, 32'h0000_0008, post); chk("R10 addr write no busy", post, 0);
    wr(1, 2'b11, 1, 32'hCAFE_F00D, post); chk("R10 single strobe store busy", post, 2);
    rd_exp(1, 2'b11, 0, 32'hCAFE_F00D, "R10 full word read", pre, post);
    chk("R10 fetch busy", pre, 2);
    rd_exp(1, 2'b01, 1, 32'hCAFE_F00D, "R10 inc read", pre, post);
    chk("R10 inc read tail busy", post, 2);
    rd_exp(1, 2'b10, 0, 32'h0000_000C, "R10 pointer advanced", pre, post);

    repeat (2) @(negedge clk);
    finish_up();
  end

endmodule